// File: doc/BRIEF.md
# Serialized Three-Product Sum Unit

This unit produces, for each element of an operand stream, the value Q = A*B + C*D + E*F. All of the arithmetic runs on one multiplier and one adder, reused over five sequential steps. Each element is taken to completion before the next is accepted. As a result, the only intermediate storage is two working registers, and that storage does not depend on how many elements the stream holds.

An upstream producer presents the six operand words together with `in_valid`. The unit raises `in_ready` while it is idle, and it latches the operands on the clock edge where both signals are high. Five steps then follow, one per clock cycle:

1. The first temporary takes A*B.
2. The second temporary takes C*D.
3. The first temporary takes the sum of the two temporaries.
4. The second temporary takes E*F.
5. The final sum is written out.

The result appears on `out_q`, and `out_valid` is high for a single cycle. The stream length is set only by how many elements the producer offers.

Top module: `tri_prod_sum`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `out_valid` is 0, `out_q` is 0 and `in_ready` is 1.
- R2: `in_ready` goes to 0 for the five cycles after an accepting edge. Values on the operand inputs and on `in_valid` during those cycles have no effect on the result being computed.
- R3: The result equals A*B + C*D + E*F as unsigned integers, exactly, at a width of 2W+2 bits. This includes the case where every operand is all ones.
- R4: After an accepting edge k, `out_valid` is 1 only in the cycle that follows edge k+5, and it stays high for exactly one cycle.
- R5: The internal step sequence always runs AB, CD, first sum, EF, final sum, then back to idle, with one step per cycle.
- R6: `out_q` holds its last result until the next result is written.
- R7: A stream of any length can be processed with `in_valid` held high. A new element is accepted on edge k+6, and each result depends only on its own operands.
- R8: While the unit is idle and `in_valid` is 0, nothing is accepted and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit idle, operand set can be taken |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_c | input | W | Operand C |
| in_d | input | W | Operand D |
| in_e | input | W | Operand E |
| in_f | input | W | Operand F |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_q | output | 2W+2 | Sum of the three products |

## Verification
The bench uses several kinds of operand sets, and each one separates a different fault:
- All-zero operands and all-ones operands show whether the result is cleared between elements and whether it is wide enough to hold the largest sum.
- Sets where only one operand pair is nonzero show whether the operand multiplexer routes the right pair to each step, and whether each temporary lands in the right place.
- Pseudo-random sets are used while junk is driven onto the inputs during the busy cycles. This shows whether the operands are latched at the accepting edge.
- A continuous stream, with `in_valid` held high, shows whether state leaks from one element into the next and whether the six-cycle acceptance spacing is kept.

// File: rtl/tps_pkg.sv
package tps_pkg;

   localparam int NOPS = 6;
   localparam int OP_A = 0;
   localparam int OP_B = 1;
   localparam int OP_C = 2;
   localparam int OP_D = 3;
   localparam int OP_E = 4;
   localparam int OP_F = 5;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_AB   = 3'd1,
      ST_CD   = 3'd2,
      ST_SUM1 = 3'd3,
      ST_EF   = 3'd4,
      ST_SUM2 = 3'd5
   } step_e;

   function automatic int acc_width(input int w);
      return 2 * w + 2;
   endfunction

endpackage

// File: rtl/tps_capture.sv
module tps_capture
   import tps_pkg::*;
#(
   parameter int W           = 8,
   parameter bit CLEAR_RESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      load,
   input  logic [NOPS-1:0][W-1:0]    ops_in,
   output logic [NOPS-1:0][W-1:0]    ops_held
);

   for (genvar g = 0; g < NOPS; g++) begin : g_op
      if (CLEAR_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)
               ops_held[g] <= '0;
            else if (load)
               ops_held[g] <= ops_in[g];
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (load)
               ops_held[g] <= ops_in[g];
         end
      end
   end

   // R2
   capture_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(ops_held));

endmodule

// File: rtl/tps_seq.sv
module tps_seq
   import tps_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  in_valid,
   output logic  in_ready,
   output logic  accept,
   output logic  done,
   output step_e step
);

   assign in_ready = (step == ST_IDLE);
   assign accept   = in_ready & in_valid;
   assign done     = (step == ST_SUM2);

   always_ff @(posedge clk) begin
      if (rst) begin
         step <= ST_IDLE;
      end else begin
         unique case (step)
            ST_IDLE: if (in_valid) step <= ST_AB;
            ST_AB:   step <= ST_CD;
            ST_CD:   step <= ST_SUM1;
            ST_SUM1: step <= ST_EF;
            ST_EF:   step <= ST_SUM2;
            ST_SUM2: step <= ST_IDLE;
            default: step <= ST_IDLE;
         endcase
      end
   end

   // R5
   ab_then_cd_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_AB) |=> (step == ST_CD));
   // R5
   cd_then_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_CD) |=> (step == ST_SUM1));
   // R5
   sum_then_ef_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_SUM1) |=> (step == ST_EF));
   // R5
   ef_then_final_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_EF) |=> (step == ST_SUM2));
   // R5
   final_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_SUM2) |=> (step == ST_IDLE));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_IDLE && !in_valid) |=> (step == ST_IDLE));

endmodule

// File: rtl/tps_opsel.sv
module tps_opsel
   import tps_pkg::*;
#(
   parameter int W = 8
) (
   input  step_e                   step,
   input  logic [NOPS-1:0][W-1:0]  ops,
   output logic [W-1:0]            mul_x,
   output logic [W-1:0]            mul_y
);

   always_comb begin
      mul_x = '0;
      mul_y = '0;
      unique case (step)
         ST_AB: begin
            mul_x = ops[OP_A];
            mul_y = ops[OP_B];
         end
         ST_CD: begin
            mul_x = ops[OP_C];
            mul_y = ops[OP_D];
         end
         ST_EF: begin
            mul_x = ops[OP_E];
            mul_y = ops[OP_F];
         end
         default: begin
            mul_x = '0;
            mul_y = '0;
         end
      endcase
   end

endmodule

// File: rtl/tps_arith.sv
module tps_arith
   import tps_pkg::*;
#(
   parameter int W     = 8,
   localparam int ACC_W = acc_width(W)
) (
   input  logic             clk,
   input  logic             rst,
   input  step_e            step,
   input  logic [W-1:0]     mul_x,
   input  logic [W-1:0]     mul_y,
   output logic [ACC_W-1:0] sum
);

   localparam int PROD_W = 2 * W;

   logic [PROD_W-1:0] prod;
   logic [ACC_W-1:0]  prod_ext;
   logic [ACC_W-1:0]  t1;
   logic [ACC_W-1:0]  t2;

   assign prod     = {{W{1'b0}}, mul_x} * {{W{1'b0}}, mul_y};
   assign prod_ext = {{(ACC_W-PROD_W){1'b0}}, prod};
   assign sum      = t1 + t2;

   always_ff @(posedge clk) begin
      if (rst) begin
         t1 <= '0;
      end else begin
         unique case (step)
            ST_AB:   t1 <= prod_ext;
            ST_SUM1: t1 <= sum;
            default: t1 <= t1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         t2 <= '0;
      end else begin
         unique case (step)
            ST_CD:   t2 <= prod_ext;
            ST_EF:   t2 <= prod_ext;
            default: t2 <= t2;
         endcase
      end
   end

   // R3
   sum_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_SUM1 || step == ST_SUM2) |-> (sum >= t1 && sum >= t2));
   // R3
   partial_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_SUM1) |=> (t1 == $past(sum)));

endmodule

// File: rtl/tri_prod_sum.sv
module tri_prod_sum
   import tps_pkg::*;
#(
   parameter int W           = 8,
   parameter bit CLEAR_RESET = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [W-1:0]   in_a,
   input  logic [W-1:0]   in_b,
   input  logic [W-1:0]   in_c,
   input  logic [W-1:0]   in_d,
   input  logic [W-1:0]   in_e,
   input  logic [W-1:0]   in_f,
   output logic           out_valid,
   output logic [2*W+1:0] out_q
);

   localparam int ACC_W = acc_width(W);

   initial begin
      width_range_chk: assert (W >= 1 && W <= 32)
         else $error("tri_prod_sum: W out of range");
   end

   logic                     accept;
   logic                     done;
   step_e                    step;
   logic [NOPS-1:0][W-1:0]   ops_in;
   logic [NOPS-1:0][W-1:0]   ops_held;
   logic [W-1:0]             mul_x;
   logic [W-1:0]             mul_y;
   logic [ACC_W-1:0]         sum;

   assign ops_in = {in_f, in_e, in_d, in_c, in_b, in_a};

   tps_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .accept   (accept),
      .done     (done),
      .step     (step)
   );

   tps_capture #(.W(W), .CLEAR_RESET(CLEAR_RESET)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .ops_in   (ops_in),
      .ops_held (ops_held)
   );

   tps_opsel #(.W(W)) u_sel (
      .step  (step),
      .ops   (ops_held),
      .mul_x (mul_x),
      .mul_y (mul_y)
   );

   tps_arith #(.W(W)) u_arith (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .mul_x (mul_x),
      .mul_y (mul_y),
      .sum   (sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_q     <= '0;
      end else begin
         out_valid <= done;
         if (done)
            out_q <= sum;
      end
   end

   // R4
   pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   // R4
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(accept, 6));
   // R2
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready);
   // R6
   hold_q_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_q));

endmodule

// File: tb/tri_prod_sum_tb.sv
module tri_prod_sum_tb;

   localparam int W     = 8;
   localparam int ACC_W = 2 * W + 2;

   logic             clk = 1'b0;
   logic             rst;
   logic             in_valid;
   logic             in_ready;
   logic [W-1:0]     in_a, in_b, in_c, in_d, in_e, in_f;
   logic             out_valid;
   logic [ACC_W-1:0] out_q;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   tri_prod_sum #(.W(W)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_a      (in_a),
      .in_b      (in_b),
      .in_c      (in_c),
      .in_d      (in_d),
      .in_e      (in_e),
      .in_f      (in_f),
      .out_valid (out_valid),
      .out_q     (out_q)
   );

   function automatic logic [ACC_W-1:0] model(input logic [W-1:0] a, b, c, d, e, f);
      longint unsigned r;
      r = longint'(a) * longint'(b) + longint'(c) * longint'(d) + longint'(e) * longint'(f);
      return r[ACC_W-1:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_ops(input logic [W-1:0] a, b, c, d, e, f);
      in_a = a; in_b = b; in_c = c; in_d = d; in_e = e; in_f = f;
   endtask

   // One element: accept, watch five busy cycles, check the result and its hold.
   task automatic do_elem(input logic [W-1:0] a, b, c, d, e, f,
                          input bit junk, input string tag);
      logic [ACC_W-1:0] exp;
      bit busy_ok;
      exp = model(a, b, c, d, e, f);
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", {tag, " ready before accept"}, in_ready, 1);
      drive_ops(a, b, c, d, e, f);
      in_valid = 1'b1;
      busy_ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (in_ready !== 1'b0 || out_valid !== 1'b0) busy_ok = 1'b0;
         if (junk) begin
            drive_ops(W'($urandom), W'($urandom), W'($urandom),
                      W'($urandom), W'($urandom), W'($urandom));
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
      chk(busy_ok, "R5", {tag, " busy window"}, busy_ok, 1);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R4", {tag, " strobe at edge k+5"}, out_valid, 1);
      chk(out_q == exp, "R3", {tag, " result"}, out_q, exp);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", {tag, " strobe one cycle"}, out_valid, 0);
      chk(out_q == exp, "R6", {tag, " result held"}, out_q, exp);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      drive_ops('0, '0, '0, '0, '0, '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(out_q == '0, "R1", "out_q in reset", out_q, 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset release",
          {out_valid, in_ready}, 2'b01);
   endtask

   task automatic t_idle();
      bit quiet;
      quiet = 1'b1;
      in_valid = 1'b0;
      drive_ops('1, '1, '1, '1, '1, '1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (out_valid !== 1'b0 || in_ready !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R8", "idle with in_valid low", quiet, 1);
   endtask

   task automatic t_corners();
      do_elem('0, '0, '0, '0, '0, '0, 1'b0, "R3 zeros");
      do_elem('1, '1, '1, '1, '1, '1, 1'b0, "R3 all ones");
      do_elem(8'd7, 8'd9, '0, '0, '0, '0, 1'b0, "R3 AB only");
      do_elem('0, '0, 8'd11, 8'd13, '0, '0, 1'b0, "R3 CD only");
      do_elem('0, '0, '0, '0, 8'd17, 8'd19, 1'b0, "R3 EF only");
      do_elem(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 1'b0, "R3 distinct");
   endtask

   task automatic t_junk_busy();
      for (int i = 0; i < 6; i++)
         do_elem(W'($urandom), W'($urandom), W'($urandom),
                 W'($urandom), W'($urandom), W'($urandom), 1'b1, "R2 junk while busy");
   endtask

   // R7: continuous stream, next element offered on the strobe cycle.
   task automatic t_stream();
      localparam int N = 16;
      logic [W-1:0] op [N][6];
      bit spacing_ok;
      for (int n = 0; n < N; n++)
         for (int j = 0; j < 6; j++)
            op[n][j] = (n == 3) ? '1 : W'($urandom);
      spacing_ok = 1'b1;
      @(negedge clk);
      drive_ops(op[0][0], op[0][1], op[0][2], op[0][3], op[0][4], op[0][5]);
      in_valid = 1'b1;
      for (int n = 0; n < N; n++) begin
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (in_ready !== 1'b0 || out_valid !== 1'b0) spacing_ok = 1'b0;
         end
         @(negedge clk);
         chk(out_valid == 1'b1 && out_q == model(op[n][0], op[n][1], op[n][2],
                                                 op[n][3], op[n][4], op[n][5]),
             "R7", "stream element result", out_q,
             model(op[n][0], op[n][1], op[n][2], op[n][3], op[n][4], op[n][5]));
         if (in_ready !== 1'b1) spacing_ok = 1'b0;
         if (n + 1 < N)
            drive_ops(op[n+1][0], op[n+1][1], op[n+1][2],
                      op[n+1][3], op[n+1][4], op[n+1][5]);
         else
            in_valid = 1'b0;
      end
      chk(spacing_ok, "R7", "six-cycle spacing in stream", spacing_ok, 1);
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", "no strobe after stream", out_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_idle();
      t_corners();
      t_junk_busy();
      t_stream();
      t_idle();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule